// File: doc/BRIEF.md
# Serial Six-Bit Pattern Detector

This block watches a one-bit serial stream. It raises a flag whenever the six most recent bits, the live input included, form a fixed target word. The block keeps no state machine. A five-stage serial-in parallel-out shift register holds the bits from the five previous cycles. A comparator checks those five bits, together with the unregistered live bit, against the target on every cycle.

The flag is purely combinational from the live bit and the stored history. It can therefore change inside a cycle when the input changes, with no clock edge needed. A detection never clears the history, so occurrences that overlap are each reported. The window length, the target word and the comparator variant are elaboration parameters. The default window length is six and the default target is 100101.

Top module: `ptn_serial_detector`

## Requirements
- R1: `hit` is 1 exactly when bit_in(t), bit_in(t-1), bit_in(t-2), bit_in(t-3), bit_in(t-4) and bit_in(t-5) are 1, 0, 0, 1, 0 and 1. Here t is the current cycle and t-k is the bit sampled k rising edges earlier. In arrival order, oldest first, the stream reads 1,0,1,0,0,1. `PATTERN` bit 5 holds the t position and bit 0 holds the t-5 position.
- R2: The live `bit_in` enters the comparison without being registered. A change on `bit_in` between clock edges changes `hit` in the same cycle.
- R3: Only the five previous bits and the live bit affect `hit`. A bit six or more edges old has no influence.
- R4: The history advances by exactly one bit on every rising edge of `clk`. The sampled `bit_in` enters the newest position, so a match appears on the sixth bit of the sequence and not one cycle earlier or later.
- R5: Overlapping occurrences are each reported. The stream 1,0,1,0,0,1,0,1,0,0,1 gives `hit` on its 6th and 11th bits.
- R6: An active-low `rst_n` clears the history to zeros asynchronously. While `rst_n` is low, `hit` stays 0. After the release, `hit` stays 0 until at least five bits have been shifted in.
- R7: A reset in the middle of a stream discards the partial history. The bits sent before the reset cannot complete a match afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit is taken per edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the history |
| bit_in | input | 1 | Serial stream bit, also compared directly in the current cycle |
| hit | output | 1 | Combinational match flag for the current six-bit window |

## Verification
On every cycle, the embedded properties check several things. The newest history stage must equal the bit sampled at the previous edge, and each older stage must take over its neighbour's previous value. A raised `hit` must agree with the target in the live bit and in the bit of the previous cycle. `hit` must stay low until five bits have arrived after reset. Only the bench's scenarios can show the rest of the behaviour: that the flag tracks a mid-cycle input change, that overlapping matches are both seen, that bits older than the window are ignored, and that a reset during a partial match discards it. The bench also compares every cycle of a long pseudo-random stream against an independent six-bit model, with the target inserted into the stream at intervals.

// File: rtl/ptn_det_pkg.sv
package ptn_det_pkg;

   // Comparator implementation variants selectable at elaboration.
   typedef enum logic [0:0] {
      CMP_EQ   = 1'b0,  // single vector equality
      CMP_XNOR = 1'b1   // per-bit agreement vector, then AND reduction
   } cmp_style_e;

   localparam int unsigned DEF_WIN_LEN = 6;

endpackage

// File: rtl/ptn_hist_shreg.sv
// Serial-in parallel-out history register. Bit HIST_W-1 holds the newest
// sampled bit (t-1), bit 0 the oldest (t-HIST_W).
module ptn_hist_shreg #(
   parameter int unsigned HIST_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   output logic [HIST_W-1:0] hist_o
);

   generate
      if (HIST_W < 1) begin : g_bad_w
         $error("ptn_hist_shreg: HIST_W must be at least 1");
      end
   endgenerate

   for (genvar k = 0; k < HIST_W; k++) begin : g_stage
      logic stage_d;
      logic stage_q;

      if (k == HIST_W - 1) begin : g_head
         assign stage_d = din;
      end else begin : g_body
         assign stage_d = hist_o[k+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= 1'b0;
         end else begin
            stage_q <= stage_d;
         end
      end

      assign hist_o[k] = stage_q;
   end

   // R4
   hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> hist_o[HIST_W-1] == $past(din))
      else $error("newest history stage did not capture the input");

   generate
      if (HIST_W > 1) begin : g_move_chk
         // R4
         hist_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> hist_o[HIST_W-2:0] == $past(hist_o[HIST_W-1:1]))
            else $error("history did not advance by one position");
      end
   endgenerate

endmodule

// File: rtl/ptn_window_cmp.sv
// Compares the live bit plus the stored history against a fixed target.
module ptn_window_cmp
   import ptn_det_pkg::*;
#(
   parameter int unsigned WIN_LEN   = DEF_WIN_LEN,
   parameter logic [WIN_LEN-1:0] TARGET = '0,
   parameter cmp_style_e  CMP_STYLE = CMP_EQ
) (
   input  logic               live_bit,
   input  logic [WIN_LEN-2:0] hist,
   output logic               match_o
);

   logic [WIN_LEN-1:0] window;

   // Window MSB is the live bit, LSB the oldest stored bit.
   assign window = {live_bit, hist};

   generate
      if (CMP_STYLE == CMP_XNOR) begin : g_xnor
         logic [WIN_LEN-1:0] agree;
         assign agree   = ~(window ^ TARGET);
         assign match_o = &agree;
      end else begin : g_eq
         assign match_o = (window == TARGET);
      end
   endgenerate

endmodule

// File: rtl/ptn_serial_detector.sv
module ptn_serial_detector
   import ptn_det_pkg::*;
#(
   parameter int unsigned WIN_LEN   = DEF_WIN_LEN,
   parameter logic [WIN_LEN-1:0] PATTERN = 6'b100101,
   parameter cmp_style_e  CMP_STYLE = CMP_EQ
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   output logic hit
);

   localparam int unsigned HIST_W = WIN_LEN - 1;
   localparam int unsigned CNT_W  = $clog2(HIST_W + 1);

   generate
      if (WIN_LEN < 2) begin : g_bad_len
         $error("ptn_serial_detector: WIN_LEN must be at least 2");
      end
   endgenerate

   logic [HIST_W-1:0] hist;

   ptn_hist_shreg #(
      .HIST_W (HIST_W)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (bit_in),
      .hist_o (hist)
   );

   ptn_window_cmp #(
      .WIN_LEN   (WIN_LEN),
      .TARGET    (PATTERN),
      .CMP_STYLE (CMP_STYLE)
   ) u_cmp (
      .live_bit (bit_in),
      .hist     (hist),
      .match_o  (hit)
   );

   // Assertion-only bookkeeping: bits shifted in since reset, saturating.
   logic [CNT_W-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (fill_q < CNT_W'(HIST_W)) begin
         fill_q <= fill_q + CNT_W'(1);
      end
   end

   // R1
   hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> bit_in == PATTERN[WIN_LEN-1])
      else $error("hit raised with a live bit that disagrees with the target");

   // R1
   hit_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && fill_q != '0) |-> $past(bit_in) == PATTERN[WIN_LEN-2])
      else $error("hit raised with a previous bit that disagrees with the target");

   generate
      if (PATTERN[0]) begin : g_early_chk
         // R6
         early_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_q < CNT_W'(HIST_W)) |-> !hit)
            else $error("hit raised before the history was filled");
      end
   endgenerate

endmodule

// File: tb/ptn_serial_detector_tb_top.sv
module ptn_serial_detector_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] REF_PAT = 6'b100101;

   logic clk    = 1'b0;
   logic rst_n  = 1'b0;
   logic bit_in = 1'b0;
   logic hit;

   int n_chk  = 0;
   int n_fail = 0;
   logic [4:0] mhist = '0;   // bench model: [4] newest past bit, [0] oldest

   always #(CLK_PERIOD/2) clk = ~clk;

   ptn_serial_detector dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (bit_in),
      .hit    (hit)
   );

   task automatic check(input string rq, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: hit=%b expected %b at %0t", rq, act, exp, $time);
      end
   endtask

   // Drive one bit at the falling edge, check mid-cycle, advance the model.
   task automatic send(input logic b, input string rq, output logic seen);
      @(negedge clk);
      bit_in = b;
      #(CLK_PERIOD/4);
      seen = hit;
      check(rq, hit, ({b, mhist} == REF_PAT));
      mhist = {b, mhist[4:1]};
   endtask

   // Send n bits of seq, oldest (bit n-1) first; returns number of hits.
   task automatic send_seq(input logic [31:0] seq, input int n, input string rq,
                           output int hits);
      logic s;
      hits = 0;
      for (int i = n - 1; i >= 0; i--) begin
         send(seq[i], rq, s);
         if (s === 1'b1) hits++;
      end
   endtask

   task automatic do_reset(input logic drv);
      @(negedge clk);
      rst_n  = 1'b0;
      bit_in = drv;
      mhist  = '0;
      #(CLK_PERIOD/4);
      check("R6 reset holds hit low", hit, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      int h;
      do_reset(1'b1);
      // first five bits after reset: fragment of the pattern, no hit allowed
      send_seq(32'b10100, 5, "R6 no hit before five bits", h);
      check("R6 hit count over first five bits", h != 0, 1'b0);
   endtask

   task automatic t_single();
      int h;
      logic s;
      do_reset(1'b0);
      send_seq(32'b101001, 6, "R1 single match", h);
      check("R1 exactly one hit", h == 1, 1'b1);
      send(1'b0, "R4 window moved on", s);
      check("R4 no hit on the following bit", s, 1'b0);
   endtask

   task automatic t_overlap();
      int h;
      do_reset(1'b0);
      send_seq(32'b10100101001, 11, "R5 overlapping matches", h);
      check("R5 both overlapping hits seen", h == 2, 1'b1);
   endtask

   task automatic t_comb();
      int h;
      do_reset(1'b0);
      send_seq(32'b10100, 5, "R2 prefix", h);
      @(negedge clk);
      bit_in = 1'b0;
      #(CLK_PERIOD/8);
      check("R2 live bit 0 gives no hit", hit, 1'b0);
      bit_in = 1'b1;
      #(CLK_PERIOD/8);
      check("R2 live bit 1 raises hit before any edge", hit, 1'b1);
      bit_in = 1'b0;
      #(CLK_PERIOD/8);
      check("R2 live bit back to 0 drops hit", hit, 1'b0);
      mhist = {1'b0, mhist[4:1]};
   endtask

   task automatic t_old_bits();
      int h;
      do_reset(1'b0);
      send_seq(32'b1111111, 7, "R3 ones preamble", h);
      send_seq(32'b01001, 5, "R3 match after ones", h);
      check("R3 hit despite older ones", h == 1, 1'b1);
      do_reset(1'b0);
      send_seq(32'b0000000, 7, "R3 zeros preamble", h);
      send_seq(32'b101001, 6, "R3 match after zeros", h);
      check("R3 hit despite older zeros", h == 1, 1'b1);
   endtask

   task automatic t_midreset();
      int h;
      logic s;
      do_reset(1'b0);
      send_seq(32'b10100, 5, "R7 partial before reset", h);
      do_reset(1'b1);
      send(1'b1, "R7 completing bit after reset", s);
      check("R7 partial history discarded", s, 1'b0);
   endtask

   task automatic t_random();
      logic [15:0] lfsr = 16'hACE1;
      logic s;
      int h;
      do_reset(1'b0);
      for (int i = 0; i < 3000; i++) begin
         if (i % 97 == 50) begin
            send_seq(32'b101001, 6, "R1 random inserted", h);
         end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], "R3 random stream", s);
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      #(CLK_PERIOD/4);
      t_reset();
      t_single();
      t_overlap();
      t_comb();
      t_old_bits();
      t_midreset();
      t_random();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule